// File: doc/BRIEF.md
# Selectable Receive Event Counter

This block keeps a running tally of receive-side events for a PHY self-test path. A type select chooses, at run time, whether the tally tracks every received frame or only frames that arrived with a failed CRC check. Each frame is reported by a frame-end strobe, and a CRC-error flag accompanies it. The counter is wider than the read port. A half-select input picks whether the 16-bit window shows the upper or the lower half of the total.

A clear request zeroes the tally. Nothing about the request is latched, so counting resumes in the next cycle. The count stops at its all-ones value and does not wrap. Changing the type select leaves the accumulated value untouched. Only frames that end after the change are judged by the new selection. A strobe that stays high for several cycles counts as a single frame.

Top module: `rx_evt_counter`

## Requirements
- R1: With `cnt_type` = 1, a frame-end strobe adds one to the count only when `crc_bad` is 1. A strobe with `crc_bad` = 0 leaves the count unchanged.
- R2: With `cnt_type` = 0, every frame-end strobe adds one to the count, whatever the value of `crc_bad`.
- R3: The count is 32 bits wide. `rd_data` shows bits 31:16 when `hi_sel` = 1 and bits 15:0 when `hi_sel` = 0. The window follows `hi_sel` within the same cycle.
- R4: When `clr_req` is 1 at a rising clock edge, the count is 0 after that edge. No clear state is held, so an event in the following cycle counts normally.
- R5: When a clear and a qualifying event occur at the same edge, the count becomes 0.
- R6: After reset, the count reads 0 in both halves.
- R7: The count holds at its all-ones value and never wraps to 0.
- R8: Changing `cnt_type` leaves the count unchanged.
- R9: A strobe held high for several cycles counts once. `crc_bad` is sampled only in the first cycle of the strobe.
- R10: In a cycle with no new strobe and no clear, the count keeps its value.
- R11: A qualifying event raises the count by exactly one, and the new value is visible on `rd_data` after the edge that samples the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_end | input | 1 | Frame-end strobe; its rising edge marks one frame |
| crc_bad | input | 1 | CRC check of the ending frame failed |
| cnt_type | input | 1 | 0 counts frames, 1 counts CRC-failed frames |
| clr_req | input | 1 | Clear request, acted on at the edge where it is high |
| hi_sel | input | 1 | 1 selects the upper half of the count, 0 the lower half |
| rd_data | output | 16 | Selected half of the count |

## Verification
The bench drives the count past 65535, so a swapped or stuck half-select shows up as a wrong upper word. It holds the strobe for several cycles while flipping `crc_bad` partway through. A design that counts levels instead of edges, or that samples the flag late, then counts extra frames. It raises a clear and an event at the same edge, where a design with the wrong priority ends at 1 instead of 0, and it counts again right after a clear to expose a latched clear. A narrow second instance is driven past its all-ones value, where a wrapping counter would read 0.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
   typedef enum logic {
      EVT_ALL_FRAMES = 1'b0,
      EVT_CRC_FAIL   = 1'b1
   } evt_kind_e;
endpackage

// File: rtl/rxc_qualify.sv
module rxc_qualify
   import rxc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic frame_end,
   input  logic crc_bad,
   input  logic cnt_type,
   output logic evt
);
   logic      strobe_prev_q;
   logic      strobe_rise;
   evt_kind_e kind;

   assign kind        = evt_kind_e'(cnt_type);
   assign strobe_rise = frame_end & ~strobe_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_prev_q <= 1'b0;
      else        strobe_prev_q <= frame_end;
   end

   always_comb begin
      unique case (kind)
         EVT_CRC_FAIL:   evt = strobe_rise & crc_bad;
         default:        evt = strobe_rise;
      endcase
   end
endmodule

// File: rtl/rxc_accum.sv
module rxc_accum #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt,
   input  logic             clr,
   output logic [CNT_W-1:0] count_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic at_max;
   assign at_max = (count_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                count_q <= '0;
      else if (clr)              count_q <= '0;
      else if (evt && !at_max)   count_q <= count_q + CNT_ONE;
   end
endmodule

// File: rtl/rxc_window.sv
module rxc_window #(
   parameter int CNT_W = 32,
   parameter int WIN_W = 16
) (
   input  logic [CNT_W-1:0] count,
   input  logic             hi_sel,
   output logic [WIN_W-1:0] rd_data
);
   localparam int NUM_WIN = CNT_W / WIN_W;

   logic [WIN_W-1:0] part [NUM_WIN];

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_part
      assign part[g] = count[g*WIN_W +: WIN_W];
   end

   assign rd_data = part[hi_sel];
endmodule

// File: rtl/rx_evt_counter.sv
module rx_evt_counter #(
   parameter int CNT_W = 32,
   parameter int WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_end,
   input  logic             crc_bad,
   input  logic             cnt_type,
   input  logic             clr_req,
   input  logic             hi_sel,
   output logic [WIN_W-1:0] rd_data
);
   if (WIN_W < 1) begin : g_bad_win
      $error("rx_evt_counter: WIN_W must be at least 1");
   end
   if (CNT_W != 2 * WIN_W) begin : g_bad_ratio
      $error("rx_evt_counter: CNT_W must be twice WIN_W");
   end

   logic             evt;
   logic [CNT_W-1:0] count_q;

   rxc_qualify u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .crc_bad   (crc_bad),
      .cnt_type  (cnt_type),
      .evt       (evt)
   );

   rxc_accum #(.CNT_W(CNT_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt     (evt),
      .clr     (clr_req),
      .count_q (count_q)
   );

   rxc_window #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_win (
      .count   (count_q),
      .hi_sel  (hi_sel),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_end,
   input logic             clr_req,
   input logic [CNT_W-1:0] count_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req |=> (count_q == '0)); // R4

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNT_MAX && !clr_req) |=> (count_q == CNT_MAX)); // R7

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_req |=> (count_q == $past(count_q) || count_q == $past(count_q) + 1'b1)); // R11

   AST_HELD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_end && $past(frame_end) && !clr_req) |=> $stable(count_q)); // R9

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_end && !clr_req) |=> $stable(count_q)); // R10
endmodule

bind rx_evt_counter rxc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_end (frame_end),
   .clr_req   (clr_req),
   .count_q   (count_q)
);

// File: tb/sim_rx_evt_counter.sv
`timescale 1ns/1ps
module sim_rx_evt_counter;
   typedef struct {
      logic [31:0] exp;
      string       req;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_end = 1'b0, crc_bad = 1'b0, cnt_type = 1'b0, clr_req = 1'b0, hi_sel = 1'b0;
   logic [15:0] rd_data;

   logic        s_fe = 1'b0, s_hi = 1'b0;
   logic [3:0]  s_rd;

   int          n_chk = 0, n_fail = 0;
   item_t       sbq[$];
   logic [31:0] model = '0;
   logic        prev_fe = 1'b0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   rx_evt_counter u0 (
      .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .crc_bad(crc_bad),
      .cnt_type(cnt_type), .clr_req(clr_req), .hi_sel(hi_sel), .rd_data(rd_data)
   );

   rx_evt_counter #(.CNT_W(8), .WIN_W(4)) u1 (
      .clk(clk), .rst_n(rst_n), .frame_end(s_fe), .crc_bad(1'b0),
      .cnt_type(1'b0), .clr_req(1'b0), .hi_sel(s_hi), .rd_data(s_rd)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // driver: one clock cycle of stimulus, then push the predicted count
   task automatic step(logic fe, logic crc, logic typ, logic clr, string req);
      item_t it;
      @(negedge clk);
      frame_end = fe; crc_bad = crc; cnt_type = typ; clr_req = clr;
      @(posedge clk);
      if (clr) model = '0;
      else if (fe && !prev_fe && (typ ? crc : 1'b1) && model != 32'hFFFF_FFFF)
         model = model + 1;
      prev_fe = fe;
      it.exp = model; it.req = req;
      sbq.push_back(it);
   endtask

   task automatic pulse(logic crc, logic typ, string req);
      step(1'b1, crc, typ, 1'b0, req);
      step(1'b0, 1'b0, typ, 1'b0, req);
   endtask

   // monitor: reads both halves between edges (R3) and compares
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sbq.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it = sbq.pop_front();
            hi_sel = 1'b0; #1; got[15:0]  = rd_data;
            hi_sel = 1'b1; #1; got[31:16] = rd_data;
            check(it.req, got, it.exp);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      step(1'b0, 1'b0, 1'b0, 1'b0, "R6");
      // R2: all frames counted, flag ignored
      pulse(1'b0, 1'b0, "R2");
      pulse(1'b1, 1'b0, "R2");
      pulse(1'b0, 1'b0, "R11");
      // R8: switch type, count kept
      step(1'b0, 1'b0, 1'b1, 1'b0, "R8");
      // R1: only CRC-failed frames counted
      pulse(1'b0, 1'b1, "R1");
      pulse(1'b1, 1'b1, "R1");
      pulse(1'b0, 1'b1, "R1");
      // R9: held strobe, flag rises late -> not counted in CRC mode
      step(1'b1, 1'b0, 1'b1, 1'b0, "R9");
      step(1'b1, 1'b1, 1'b1, 1'b0, "R9");
      step(1'b1, 1'b1, 1'b1, 1'b0, "R9");
      step(1'b0, 1'b0, 1'b1, 1'b0, "R10");
      // R9: held strobe in frame mode counted once
      step(1'b1, 1'b0, 1'b0, 1'b0, "R9");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R9");
      step(1'b1, 1'b0, 1'b0, 1'b0, "R9");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R10");
      // R4: clear, then count right after
      step(1'b0, 1'b0, 1'b0, 1'b1, "R4");
      pulse(1'b0, 1'b0, "R4");
      // R5: clear and event at one edge
      step(1'b1, 1'b1, 1'b0, 1'b1, "R5");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R5");
      // R3: carry into upper half
      for (int i = 0; i < 65540; i++) pulse(1'b0, 1'b0, "R3");
      step(1'b0, 1'b0, 1'b0, 1'b0, "R3");
      @(posedge clk); @(posedge clk);
      // R7: narrow instance driven past all ones
      for (int i = 0; i < 260; i++) begin
         @(negedge clk); s_fe = 1'b1;
         @(negedge clk); s_fe = 1'b0;
      end
      @(negedge clk);
      s_hi = 1'b0; #1; check("R7", {28'd0, s_rd}, 32'hF);
      s_hi = 1'b1; #1; check("R7", {28'd0, s_rd}, 32'hF);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule